// File: doc/BRIEF.md
# Masked Interrupt Summary Register Bank

This block gathers nineteen level-sensitive interrupt request lines from an expansion bus (four request pins for each of four card slots, plus one request each from a bus bridge, a disk controller and a USB controller) into a single combined request toward the processor. Every line first passes through a two-flop synchronizer. The synchronized levels can be read back over a byte-wide I/O port as three consecutive byte registers at base, base+1 and base+2. The default base is 0x804.

Each source has a mask bit that software can write but never read. Writing a byte at one of the three addresses loads that slice of the mask. Reading any of the three addresses returns the live synchronized levels of the sources, with the mask not applied. The mask has one effect only: it gates the registered OR that drives the processor request. Start-up code normally writes 0xFF to all three addresses, and reset already leaves every source disabled.

Top module: `irq_summary_bank`

## Requirements
- R1: After reset every mask bit is 1, `cpu_irq` is 0 and `bus_rdata` is 0x00, whatever the source levels are.
- R2: The byte at base (0x804) holds these bits: 0..3 are request A of slots 0..3, 4 is the bridge, 5 is the disk controller, 6 is USB, and 7 is request B of slot 0.
- R3: The byte at base+1 (0x805) holds these bits: 0..2 are request B of slots 1..3, 3..6 are request C of slots 0..3, and 7 is request D of slot 0.
- R4: The byte at base+2 (0x806) holds request D of slots 1..3 in bits 0..2. Bits 3..7 are reserved and always read 0.
- R5: A read captures the synchronized, unmasked source levels into `bus_rdata` on the clock edge where `bus_rd` is high. The mask can never be observed through a read, and this holds even when a write to the same address happens in the same cycle.
- R6: A mask bit of 1 disables its source and a mask bit of 0 enables it. A write at base+k loads mask bits 8k..8k+7 from `bus_wdata`, and the other bytes of the mask keep their values.
- R7: `cpu_irq` is registered. A mask change takes effect on `cpu_irq` at the clock edge after the edge that performs the write. A change on a source pin reaches `cpu_irq` on the third clock edge after the pin changes.
- R8: `cpu_irq` stays high for as long as any enabled source stays high, and it falls once no enabled source is high.
- R9: An access outside base..base+2 has no effect. A write there changes no mask bit, and a read there returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | I/O byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| slot_inta | input | 4 | Request A of slots 0..3 |
| slot_intb | input | 4 | Request B of slots 0..3 |
| slot_intc | input | 4 | Request C of slots 0..3 |
| slot_intd | input | 4 | Request D of slots 0..3 |
| bridge_req | input | 1 | Bus bridge request |
| disk_req | input | 1 | Disk controller request |
| usb_req | input | 1 | USB controller request |
| cpu_irq | output | 1 | Combined registered request to the processor |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a mask write and a source edge. The bench raises a source pin in the same cycle as the write that enables it, then checks that `cpu_irq` follows the slower synchronizer path: it must still be low at the edge after the write and high at the third edge. The second pair is a read and a write at the same address in the same cycle. With a known pattern on the pins, the bench issues both strobes together and checks that the returned byte equals the pin pattern and not the written mask value. It then checks that the write still took effect on `cpu_irq`.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;
    localparam int NUM_SRC   = 19;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = (NUM_SRC + BYTE_W - 1) / BYTE_W;
    localparam int MASK_W    = NUM_BYTES * BYTE_W;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [BYTE_W-1:0] rdata;
        logic              irq;
    } irqsum_state_t;

    // Fixed bit order; software decodes these positions.
    function automatic logic [NUM_SRC-1:0] pack_sources(
        input logic [3:0] inta,
        input logic [3:0] intb,
        input logic [3:0] intc,
        input logic [3:0] intd,
        input logic       bridge,
        input logic       disk,
        input logic       usb
    );
        return {intd[3:1], intd[0], intc[3:0], intb[3:1],
                intb[0], usb, disk, bridge, inta[3:0]};
    endfunction
endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
    parameter int WIDTH  = 19,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_in;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqsum_decode.sv
module irqsum_decode #(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_BYTES = 3,
    parameter logic [11:0] BASE_ADDR = 12'h804
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BYTES-1:0] byte_sel
);
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_sel
        localparam logic [ADDR_W-1:0] HIT = ADDR_W'(BASE_ADDR) + ADDR_W'(b);
        assign byte_sel[b] = (addr == HIT);
    end
endmodule

// File: rtl/irq_summary_bank.sv
module irq_summary_bank
    import irqsum_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter logic [11:0] BASE_ADDR   = 12'h804,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [3:0]        slot_inta,
    input  logic [3:0]        slot_intb,
    input  logic [3:0]        slot_intc,
    input  logic [3:0]        slot_intd,
    input  logic              bridge_req,
    input  logic              disk_req,
    input  logic              usb_req,
    output logic              cpu_irq
);
    logic [NUM_SRC-1:0]   raw_async;
    logic [NUM_SRC-1:0]   raw_sync;
    logic [MASK_W-1:0]    raw_pad;
    logic [NUM_BYTES-1:0] byte_sel;

    irqsum_state_t state_d, state_q;

    assign raw_async = pack_sources(slot_inta, slot_intb, slot_intc, slot_intd,
                                    bridge_req, disk_req, usb_req);

    irqsum_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_async),
        .sync_out (raw_sync)
    );

    irqsum_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr     (bus_addr),
        .byte_sel (byte_sel)
    );

    assign raw_pad = MASK_W'(raw_sync);

    always_comb begin
        state_d = state_q;

        // Mask: reserved positions are pinned at 1 and never written.
        for (int i = 0; i < MASK_W; i++) begin
            if (i >= NUM_SRC) begin
                state_d.mask[i] = 1'b1;
            end else if (bus_wr && byte_sel[i / BYTE_W]) begin
                state_d.mask[i] = bus_wdata[i % BYTE_W];
            end
        end

        // Readback shows live levels; the mask never appears here.
        if (bus_rd) begin
            state_d.rdata = '0;
            for (int i = 0; i < MASK_W; i++) begin
                if (byte_sel[i / BYTE_W]) begin
                    state_d.rdata[i % BYTE_W] = raw_pad[i];
                end
            end
        end

        state_d.irq = |(raw_pad & ~state_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mask  <= '1;
            state_q.rdata <= '0;
            state_q.irq   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign cpu_irq   = state_q.irq;
endmodule

// File: rtl/irqsum_checker.sv
module irqsum_checker #(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] BASE_ADDR = 12'h804,
    parameter int          NUM_SRC   = 19,
    parameter int          MASK_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              cpu_irq,
    input logic [MASK_W-1:0] mask_vec,
    input logic              src_any
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE_ADDR) + ADDR_W'(2);

    logic in_range;
    assign in_range = (bus_addr >= LO) && (bus_addr <= HI);

    assert_reset_masked_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (&mask_vec[NUM_SRC-1:0]));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == HI) |=> (bus_rdata[7:3] == 5'd0));

    assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_vec[NUM_SRC-1:0]) |=> !cpu_irq);

    assert_rise_needs_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq) |-> $past(src_any, 2));

    assert_undecoded_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> (bus_rdata == 8'h00));

    assert_undecoded_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_range) |=> $stable(mask_vec));
endmodule

bind irq_summary_bank irqsum_checker #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .NUM_SRC   (irqsum_pkg::NUM_SRC),
    .MASK_W    (irqsum_pkg::MASK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .mask_vec  (state_q.mask),
    .src_any   (|raw_async)
);

// File: tb/sim_irq_summary_bank.sv
`timescale 1ns/1ps
module sim_irq_summary_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [3:0]  slot_inta = '0, slot_intb = '0, slot_intc = '0, slot_intd = '0;
    logic        bridge_req = 1'b0, disk_req = 1'b0, usb_req = 1'b0;
    logic        cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    irq_summary_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .slot_inta(slot_inta), .slot_intb(slot_intb), .slot_intc(slot_intc),
        .slot_intd(slot_intd), .bridge_req(bridge_req), .disk_req(disk_req),
        .usb_req(usb_req), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Drive pins from a 19-bit vector using the bit order of R2, R3 and R4.
    task automatic set_src(input logic [18:0] v);
        slot_inta  = v[3:0];
        bridge_req = v[4];
        disk_req   = v[5];
        usb_req    = v[6];
        slot_intb  = {v[10:8], v[7]};
        slot_intc  = v[14:11];
        slot_intd  = {v[18:16], v[15]};
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic write_mask(input logic [23:0] m);
        bus_write(12'h804, m[7:0]);
        bus_write(12'h805, m[15:8]);
        bus_write(12'h806, m[23:16]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        string tag;
        set_src('1);
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(5);
        // R1: mask all ones, so every high source is blocked
        check("R1 irq after reset", {7'd0, cpu_irq}, 8'h00);
        check("R1 rdata after reset", bus_rdata, 8'h00);

        // R5: reads are unmasked, even with the whole mask set
        bus_read(12'h804, rd); check("R2 R5 byte0 all high", rd, 8'hFF);
        bus_read(12'h805, rd); check("R3 R5 byte1 all high", rd, 8'hFF);
        bus_read(12'h806, rd); check("R4 byte2 reserved zero", rd, 8'h07);

        // Sweep every source one at a time
        for (int i = 0; i < 19; i++) begin
            tag = (i < 8) ? "R2" : (i < 16) ? "R3" : "R4";
            set_src(19'(1) << i);
            write_mask('1);
            idle(4);
            check("R6 masked source quiet", {7'd0, cpu_irq}, 8'h00);
            for (int b = 0; b < 3; b++) begin
                bus_read(12'h804 + 12'(b), rd);
                check(tag, rd, (b == i / 8) ? (8'd1 << (i % 8)) : 8'h00);
            end
            bus_write(12'h804 + 12'(i / 8), ~(8'd1 << (i % 8)));
            check("R7 mask write not yet visible", {7'd0, cpu_irq}, 8'h00);
            @(negedge clk);
            check("R6 R7 enabled source drives irq", {7'd0, cpu_irq}, 8'h01);
            // Enabling every other bit must not matter
            bus_write(12'h804 + 12'(((i + 8) % 24) / 8), 8'h00);
            bus_write(12'h804 + 12'(i / 8), 8'hFF);
            @(negedge clk);
            check("R6 disabling single source", {7'd0, cpu_irq}, 8'h00);
        end

        // R7 source latency and R8 level hold
        write_mask('0);
        set_src('0);
        idle(4);
        check("R8 idle low", {7'd0, cpu_irq}, 8'h00);
        set_src(19'h00020);
        @(negedge clk); @(negedge clk);
        check("R7 two edges after source", {7'd0, cpu_irq}, 8'h00);
        @(negedge clk);
        check("R7 third edge after source", {7'd0, cpu_irq}, 8'h01);
        idle(10);
        check("R8 level held", {7'd0, cpu_irq}, 8'h01);
        set_src(19'h40000);
        idle(6);
        check("R8 other source keeps irq", {7'd0, cpu_irq}, 8'h01);
        set_src('0);
        idle(4);
        check("R8 falls after release", {7'd0, cpu_irq}, 8'h00);

        // R9 undecoded accesses
        write_mask('1);
        set_src('1);
        idle(4);
        bus_write(12'h803, 8'h00);
        bus_write(12'h807, 8'h00);
        bus_write(12'h004, 8'h00);
        @(negedge clk);
        check("R9 stray writes ignored", {7'd0, cpu_irq}, 8'h00);
        bus_read(12'h803, rd); check("R9 read below", rd, 8'h00);
        bus_read(12'h807, rd); check("R9 read above", rd, 8'h00);

        // R5: mask is not readable
        write_mask('0);
        set_src('0);
        idle(4);
        bus_read(12'h805, rd); check("R5 mask not read back", rd, 8'h00);

        // Coincident read and write on one address
        write_mask('1);
        set_src(19'h00055);
        idle(4);
        bus_addr = 12'h804; bus_wdata = 8'h00; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R5 read during write", bus_rdata, 8'h55);
        @(negedge clk);
        check("R6 write during read applied", {7'd0, cpu_irq}, 8'h01);

        // Coincident mask enable and source rise
        write_mask('1);
        set_src('0);
        idle(4);
        bus_addr = 12'h805; bus_wdata = 8'hF7; bus_wr = 1'b1;
        set_src(19'h00800);
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        check("R7 write-edge plus one, source still syncing", {7'd0, cpu_irq}, 8'h00);
        @(negedge clk);
        check("R7 source arrives on third edge", {7'd0, cpu_irq}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule